// File: doc/BRIEF.md
# Indirect Index/Data Register Window

This block is a 16-byte I/O window that reaches a much larger memory-mapped register space through two words: a pointer word that holds a target register offset, and a data word whose accesses are forwarded to the register space at that offset. Firmware that can only touch a small I/O range uses it to program the whole register space. The lowest part of the window is reserved and has fixed behaviour.

The host side is a request/response stream. A request (offset, direction, write data, access size in bytes) is taken on a cycle where `host_req_valid` and `host_req_ready` are both high. Only one request is in flight: `host_req_ready` is high only while the block is idle. Every request, read or write, gets exactly one response, which is held unchanged on `host_rsp_valid`, `host_rsp_rdata` and `host_rsp_err` until the host raises `host_rsp_ready`. The register-space side issues a request held until `reg_req_ready`. A read then waits for a single-cycle `reg_rd_valid` strobe, which is sampled only after the request has been accepted.

Top module: `idx_win_port`

## Requirements
- R1: After reset the pointer word is 0, `host_req_ready` is 1, and `host_rsp_valid` and `reg_req_valid` are 0.
- R2: A read at any window offset 0 to 7 returns 0xFFFFFFFF with `host_rsp_err` 0, whatever its size.
- R3: A write at any window offset 0 to 7 is ignored: the pointer word is unchanged, no register-space request is issued, and the response has `host_rsp_err` 0.
- R4: A 4-byte write at offsets 8 to 11 stores all 32 data bits as the pointer word. A 4-byte read there returns the stored value.
- R5: A 4-byte write at offsets 12 to 15 issues one register-space write with `reg_req_addr` equal to the pointer word and `reg_req_wdata` equal to the host data. The request is held stable until `reg_req_ready`, and the host response follows that handshake.
- R6: A 4-byte read at offsets 12 to 15 issues one register-space read at the pointer word. It waits for `reg_rd_valid` and returns `reg_rd_data` from that cycle.
- R7: An access of size other than 4 (`host_req_size` holds the byte count: 1, 2 or 4) at offsets 8 to 15 responds with `host_rsp_err` 1 and read data 0. It leaves the pointer word unchanged and issues no register-space request.
- R8: A response is held with stable data and error until `host_rsp_ready`. While a request is in flight, `host_req_ready` stays 0.
- R9: The word selected in the upper half is (offset - 8) / 4: 0 selects the pointer word and 1 selects the data word, so the low two offset bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req_valid | input | 1 | Host request valid |
| host_req_ready | output | 1 | Block idle, can take a request |
| host_req_ofs | input | 4 | Byte offset inside the window |
| host_req_we | input | 1 | 1 = write, 0 = read |
| host_req_wdata | input | 32 | Host write data |
| host_req_size | input | 3 | Access size in bytes |
| host_rsp_valid | output | 1 | Response valid |
| host_rsp_ready | input | 1 | Host takes the response |
| host_rsp_rdata | output | 32 | Read data (0 for writes) |
| host_rsp_err | output | 1 | Access-size error |
| reg_req_valid | output | 1 | Register-space request valid |
| reg_req_ready | input | 1 | Register space takes the request |
| reg_req_we | output | 1 | Register-space request is a write |
| reg_req_addr | output | 32 | Register-space offset (pointer word) |
| reg_req_wdata | output | 32 | Register-space write data |
| reg_rd_valid | input | 1 | Register-space read data strobe |
| reg_rd_data | input | 32 | Register-space read data |

## Verification
The hardest case to reach is a register-space read that waits both on `reg_req_ready` and on a late `reg_rd_valid` while the host also delays `host_rsp_ready`. All three stalls must leave the returned word intact. The stimulus sweeps every offset, direction and size, and rotates the register-side acceptance gap, the read-return gap and the host response gap through several values. After each access it reads the pointer word back, so an ignored or rejected access that altered state shows up at the ports.

// File: rtl/idx_win_pkg.sv
package idx_win_pkg;
  typedef enum logic [2:0] {
    ACC_RSV_RD,
    ACC_RSV_WR,
    ACC_BAD,
    ACC_PTR_RD,
    ACC_PTR_WR,
    ACC_DAT_RD,
    ACC_DAT_WR
  } acc_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_RSP
  } win_state_e;
endpackage

// File: rtl/idx_win_decode.sv
module idx_win_decode
  import idx_win_pkg::*;
#(
  parameter int OFS_W      = 4,
  parameter int SIZE_W     = 3,
  parameter int RSV_BYTES  = 8,
  parameter int WORD_BYTES = 4
) (
  input  logic [OFS_W-1:0]  ofs,
  input  logic              we,
  input  logic [SIZE_W-1:0] size,
  output acc_kind_e         kind
);
  localparam int                WSH     = $clog2(WORD_BYTES);
  localparam logic [OFS_W-1:0]  RSV_OFS = OFS_W'(RSV_BYTES);
  localparam logic [SIZE_W-1:0] FULL    = SIZE_W'(WORD_BYTES);

  logic [OFS_W-1:0] rel;
  logic [OFS_W-1:0] sel;

  // word select = (offset - reserved bytes) / word bytes
  assign rel = ofs - RSV_OFS;
  assign sel = rel >> WSH;

  always_comb begin
    if (ofs < RSV_OFS || sel > OFS_W'(1)) begin
      kind = we ? ACC_RSV_WR : ACC_RSV_RD;
    end else if (size != FULL) begin
      kind = ACC_BAD;
    end else if (sel == '0) begin
      kind = we ? ACC_PTR_WR : ACC_PTR_RD;
    end else begin
      kind = we ? ACC_DAT_WR : ACC_DAT_RD;
    end
  end
endmodule

// File: rtl/idx_win_ctrl.sv
module idx_win_ctrl
  import idx_win_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req_valid,
  output logic              host_req_ready,
  input  acc_kind_e         kind,
  input  logic [DATA_W-1:0] host_req_wdata,
  output logic              host_rsp_valid,
  input  logic              host_rsp_ready,
  output logic [DATA_W-1:0] host_rsp_rdata,
  output logic              host_rsp_err,
  output logic              reg_req_valid,
  input  logic              reg_req_ready,
  output logic              reg_req_we,
  output logic [DATA_W-1:0] reg_req_addr,
  output logic [DATA_W-1:0] reg_req_wdata,
  input  logic              reg_rd_valid,
  input  logic [DATA_W-1:0] reg_rd_data
);
  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  win_state_e        state_q;
  logic [DATA_W-1:0] ptr_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] wdata_q;
  logic              err_q;
  logic              we_q;
  logic              accept;

  assign host_req_ready = (state_q == ST_IDLE);
  assign accept         = host_req_valid && host_req_ready;
  assign host_rsp_valid = (state_q == ST_RSP);
  assign host_rsp_rdata = rdata_q;
  assign host_rsp_err   = err_q;
  assign reg_req_valid  = (state_q == ST_REQ);
  assign reg_req_we     = we_q;
  assign reg_req_addr   = ptr_q;
  assign reg_req_wdata  = wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      rdata_q <= '0;
      wdata_q <= '0;
      err_q   <= 1'b0;
      we_q    <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          err_q   <= (kind == ACC_BAD);
          rdata_q <= '0;
          unique case (kind)
            ACC_RSV_RD: begin rdata_q <= ALL_ONES; state_q <= ST_RSP; end
            ACC_PTR_RD: begin rdata_q <= ptr_q;    state_q <= ST_RSP; end
            ACC_PTR_WR: begin ptr_q   <= host_req_wdata; state_q <= ST_RSP; end
            ACC_DAT_RD: begin we_q <= 1'b0; state_q <= ST_REQ; end
            ACC_DAT_WR: begin
              we_q    <= 1'b1;
              wdata_q <= host_req_wdata;
              state_q <= ST_REQ;
            end
            default:    state_q <= ST_RSP;
          endcase
        end
        ST_REQ: if (reg_req_ready) begin
          state_q <= we_q ? ST_RSP : ST_WAIT;
        end
        ST_WAIT: if (reg_rd_valid) begin
          rdata_q <= reg_rd_data;
          state_q <= ST_RSP;
        end
        ST_RSP: if (host_rsp_ready) begin
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R8: response held until taken
  a_r8_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    host_rsp_valid && !host_rsp_ready |=>
      host_rsp_valid && $stable(host_rsp_rdata) && $stable(host_rsp_err));

  // R8: single outstanding request
  a_r8_one_out: assert property (@(posedge clk) disable iff (!rst_n)
    host_rsp_valid |-> !host_req_ready);

  // R5: register-space request held until accepted
  a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req_valid && !reg_req_ready |=>
      reg_req_valid && $stable(reg_req_addr) && $stable(reg_req_we)
      && $stable(reg_req_wdata));

  // R4 / R3 / R7: pointer changes only after an accepted pointer write
  a_r4_ptr_change: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req_addr != $past(reg_req_addr)) |->
      $past(accept && kind == ACC_PTR_WR));

  // R7: size error answered directly, no register-space request
  a_r7_bad_direct: assert property (@(posedge clk) disable iff (!rst_n)
    accept && kind == ACC_BAD |=> host_rsp_valid && host_rsp_err && !reg_req_valid);

  // R6: read data only taken after the request was accepted
  a_r6_wait_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req_valid && reg_req_ready && !reg_req_we |=> !host_rsp_valid);
endmodule

// File: rtl/idx_win_port.sv
module idx_win_port
  import idx_win_pkg::*;
#(
  parameter int OFS_W      = 4,
  parameter int SIZE_W     = 3,
  parameter int DATA_W     = 32,
  parameter int RSV_BYTES  = 8,
  parameter int WORD_BYTES = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req_valid,
  output logic              host_req_ready,
  input  logic [OFS_W-1:0]  host_req_ofs,
  input  logic              host_req_we,
  input  logic [DATA_W-1:0] host_req_wdata,
  input  logic [SIZE_W-1:0] host_req_size,
  output logic              host_rsp_valid,
  input  logic              host_rsp_ready,
  output logic [DATA_W-1:0] host_rsp_rdata,
  output logic              host_rsp_err,
  output logic              reg_req_valid,
  input  logic              reg_req_ready,
  output logic              reg_req_we,
  output logic [DATA_W-1:0] reg_req_addr,
  output logic [DATA_W-1:0] reg_req_wdata,
  input  logic              reg_rd_valid,
  input  logic [DATA_W-1:0] reg_rd_data
);
  acc_kind_e kind;

  idx_win_decode #(
    .OFS_W(OFS_W), .SIZE_W(SIZE_W),
    .RSV_BYTES(RSV_BYTES), .WORD_BYTES(WORD_BYTES)
  ) u_decode (
    .ofs(host_req_ofs), .we(host_req_we), .size(host_req_size), .kind(kind)
  );

  idx_win_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .host_req_valid(host_req_valid), .host_req_ready(host_req_ready),
    .kind(kind), .host_req_wdata(host_req_wdata),
    .host_rsp_valid(host_rsp_valid), .host_rsp_ready(host_rsp_ready),
    .host_rsp_rdata(host_rsp_rdata), .host_rsp_err(host_rsp_err),
    .reg_req_valid(reg_req_valid), .reg_req_ready(reg_req_ready),
    .reg_req_we(reg_req_we), .reg_req_addr(reg_req_addr),
    .reg_req_wdata(reg_req_wdata),
    .reg_rd_valid(reg_rd_valid), .reg_rd_data(reg_rd_data)
  );
endmodule

// File: tb/idx_win_port_tb.sv
module idx_win_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req_valid = 1'b0;
  logic        host_req_ready;
  logic [3:0]  host_req_ofs = '0;
  logic        host_req_we = 1'b0;
  logic [31:0] host_req_wdata = '0;
  logic [2:0]  host_req_size = 3'd4;
  logic        host_rsp_valid;
  logic        host_rsp_ready = 1'b0;
  logic [31:0] host_rsp_rdata;
  logic        host_rsp_err;
  logic        reg_req_valid;
  logic        reg_req_ready = 1'b0;
  logic        reg_req_we;
  logic [31:0] reg_req_addr;
  logic [31:0] reg_req_wdata;
  logic        reg_rd_valid = 1'b0;
  logic [31:0] reg_rd_data = '0;

  int errors = 0;
  int checks = 0;
  int req_gap = 0;
  int rd_gap = 0;
  int reg_ops = 0;
  logic [31:0] last_addr = '0;
  logic [31:0] last_wdata = '0;
  logic        last_we = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  idx_win_port dut_i (.*);

  function automatic logic [31:0] reg_val(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A5A, a[31:16]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // register-space model
  initial begin
    int wcnt = 0;
    int rcnt = 0;
    bit pend = 0;
    forever begin
      @(negedge clk);
      reg_req_ready = 1'b0;
      reg_rd_valid  = 1'b0;
      if (pend) begin
        if (rcnt >= rd_gap) begin
          reg_rd_valid = 1'b1;
          reg_rd_data  = reg_val(last_addr);
          pend = 0;
        end else rcnt++;
      end else if (reg_req_valid) begin
        if (wcnt >= req_gap) begin
          reg_req_ready = 1'b1;
          last_addr  = reg_req_addr;
          last_wdata = reg_req_wdata;
          last_we    = reg_req_we;
          reg_ops++;
          wcnt = 0;
          if (!reg_req_we) begin pend = 1; rcnt = 0; end
        end else wcnt++;
      end
    end
  end

  task automatic xact(input logic [3:0] ofs, input logic we, input logic [31:0] wd,
                      input logic [2:0] sz, input int rgap,
                      output logic [31:0] rd, output logic e);
    @(negedge clk);
    host_req_valid = 1'b1;
    host_req_ofs = ofs; host_req_we = we; host_req_wdata = wd; host_req_size = sz;
    while (!host_req_ready) @(negedge clk);
    @(negedge clk);
    host_req_valid = 1'b0;
    while (!host_rsp_valid) @(negedge clk);
    rd = host_rsp_rdata;
    e  = host_rsp_err;
    chk(!host_req_ready, "R8 busy", {31'd0, host_req_ready}, 32'd0);
    for (int i = 0; i < rgap; i++) begin
      @(negedge clk);
      chk(host_rsp_valid && host_rsp_rdata == rd && host_rsp_err == e,
          "R8 hold", host_rsp_rdata, rd);
    end
    host_rsp_ready = 1'b1;
    @(negedge clk);
    host_rsp_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] ptr_m;
    logic [31:0] rd;
    logic [31:0] wd;
    logic        e;
    int k = 0;
    ptr_m = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(host_req_ready && !host_rsp_valid && !reg_req_valid, "R1 idle",
        {29'd0, host_req_ready, host_rsp_valid, reg_req_valid}, 32'h4);
    xact(4'd8, 1'b0, '0, 3'd4, 0, rd, e);
    chk(rd == 32'd0 && !e, "R1 ptr zero", rd, 32'd0);

    // sweep of offsets, sizes and directions
    for (int ofs = 0; ofs < 16; ofs++) begin
      for (int si = 0; si < 3; si++) begin
        for (int w = 0; w < 2; w++) begin
          logic [2:0] sz;
          int ops0;
          sz = 3'(1 << si);
          k++;
          wd = 32'h9E37_79B9 * k;
          req_gap = k % 3;
          rd_gap  = (k / 3) % 4;
          ops0 = reg_ops;
          xact(4'(ofs), w[0], wd, sz, k % 3, rd, e);
          if (ofs < 8) begin
            if (w == 0) chk(rd == 32'hFFFF_FFFF && !e, "R2 reserved read", rd, 32'hFFFF_FFFF);
            else        chk(!e && reg_ops == ops0, "R3 reserved write", {31'd0, e}, 32'd0);
          end else if (sz != 3'd4) begin
            chk(e && rd == 32'd0 && reg_ops == ops0, "R7 size error", rd, 32'd0);
          end else if (ofs < 12) begin
            if (w == 1) begin
              ptr_m = wd;
              chk(!e, "R4 ptr write", {31'd0, e}, 32'd0);
            end else chk(rd == ptr_m && !e, "R4 R9 ptr read", rd, ptr_m);
          end else if (w == 1) begin
            chk(!e && reg_ops == ops0 + 1 && last_we && last_addr == ptr_m
                && last_wdata == wd, "R5 R9 data write", last_addr, ptr_m);
          end else begin
            chk(!e && reg_ops == ops0 + 1 && !last_we && rd == reg_val(ptr_m),
                "R6 R9 data read", rd, reg_val(ptr_m));
          end
          // pointer word read back at a rotating pointer offset
          req_gap = 0;
          xact(4'(8 + (k % 4)), 1'b0, '0, 3'd4, 0, rd, e);
          chk(rd == ptr_m, "R3 R7 R4 ptr kept", rd, ptr_m);
        end
      end
    end

    // boundary: all-ones pointer with long stalls on every side
    xact(4'd11, 1'b1, 32'hFFFF_FFFF, 3'd4, 0, rd, e);
    req_gap = 5; rd_gap = 7;
    xact(4'd15, 1'b0, '0, 3'd4, 6, rd, e);
    chk(rd == reg_val(32'hFFFF_FFFF) && last_addr == 32'hFFFF_FFFF,
        "R6 long stall", rd, reg_val(32'hFFFF_FFFF));
    xact(4'd12, 1'b1, 32'h0, 3'd4, 2, rd, e);
    chk(last_we && last_wdata == 32'h0 && last_addr == 32'hFFFF_FFFF,
        "R5 long stall", last_wdata, 32'h0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule